// File: doc/BRIEF.md
# Split 32-bit Register Write Combiner

This block sits between the 16-bit register write side of a serial protocol front end and a store of 32-bit entities. The front end opens a request with a start pulse that carries a first register address and a register count. It then delivers the data words of that request one per cycle. The block steps the register address itself for each word and classifies every register by where it falls in a fixed, parameterised map. The map has boolean registers, byte registers, 16-bit registers, a region of paired registers that together hold 32-bit entities, and an unmapped region above the pairs.

A 32-bit entity lives in two adjacent registers: the lower address holds the upper half and the next address holds the lower half. A write to the upper half is only held inside the block. The store is written, as one atomic 32-bit value, only when the matching lower half arrives. That lower half may come as the next word of the same request or as a later single-register request. A lower half that has no matching held upper half produces an error pulse toward the response generator. Requests with an illegal register count and writes to unmapped registers produce error pulses as well. Every commit or error is a one-cycle registered strobe.

Top module: `split_write_combiner`

## Requirements
- R1: In the pair region (default registers 64 to 127), the register with even offset from the start of the region holds the upper 16 bits of an entity and the next register holds the lower 16 bits. A commit writes `{upper, lower}` with `st_idx` equal to the address of the upper register.
- R2: A write to an upper-half register raises neither `st_we` nor `err_pulse`. It replaces any half already held.
- R3: A write to a lower-half register whose address is one above the held upper-half address raises `st_we` for exactly one cycle, in the cycle after the word, with the combined data. `st_we` and `err_pulse` are never high together.
- R4: A write to a lower-half register with no matching held upper half raises `err_pulse` with `err_code` 1 (orphan half), raises no `st_we`, and clears the held half.
- R5: Any other write that arrives while an upper half is held discards the held half, so a following lower-half write is reported as an orphan.
- R6: A request of N registers (1 to 24) takes the next N data words at ascending addresses starting from its first address. It pairs upper and lower halves within the request and ignores data words beyond N. `txn_start` and `wd_valid` in the same cycle ignore the word.
- R7: A request count of 0 or above 24 raises `err_pulse` with `err_code` 3 in the next cycle, and the data words that follow it are ignored. A count of exactly 24 is accepted.
- R8: Boolean registers (addresses 0 to 15) commit the value 1 for any non-zero word and 0 for a zero word.
- R9: Byte registers (addresses 16 to 31) commit only bits 7:0 of the word, zero-extended. Bits 15:8 are ignored.
- R10: 16-bit registers (addresses 32 to 63) commit the word zero-extended to 32 bits.
- R11: A write to an address at or above the end of the pair region (default 128) raises `err_pulse` with `err_code` 2.
- R12: Synchronous active-high reset clears the held half and all output strobes. When no strobe is high, `st_idx`, `st_data` and `err_code` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txn_start | input | 1 | Opens a write request |
| txn_addr | input | 8 | First register address of the request |
| txn_count | input | 8 | Number of registers in the request |
| wd_valid | input | 1 | A data word of the open request is present |
| wd_data | input | 16 | Data word, bits 15:8 first byte, bits 7:0 second byte |
| st_we | output | 1 | One-cycle store write strobe |
| st_idx | output | 8 | Entity index (register address of the entity) |
| st_data | output | 32 | Value written to the store |
| err_pulse | output | 1 | One-cycle error strobe toward the response generator |
| err_code | output | 2 | 1 orphan half, 2 unmapped address, 3 illegal count |

## Verification
On every cycle, the assertions check that a held upper half never writes the store and that a matching lower half always commits with its own data in the following cycle. They also check that an unmatched lower half, an illegal count and an unmapped address each produce the right error code, that boolean commits are 0 or 1, and that a commit and an error never coincide. Other behaviours can only be shown by the bench's scenarios: pairs split across requests, a held half being replaced or discarded by an intervening write, words past the request count being ignored, the 24-register boundary, and the loss of the held half on reset.

// File: rtl/split_write_pkg.sv
package split_write_pkg;

    localparam int REG_W = 16;
    localparam int ENT_W = 32;

    typedef enum logic [2:0] {
        CLS_BOOL = 3'd0,
        CLS_BYTE = 3'd1,
        CLS_WORD = 3'd2,
        CLS_HI   = 3'd3,
        CLS_LO   = 3'd4,
        CLS_BAD  = 3'd5
    } reg_class_e;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_ORPHAN   = 2'd1,
        ERR_BADADDR  = 2'd2,
        ERR_BADCOUNT = 2'd3
    } err_code_e;

endpackage

// File: rtl/swc_txn_seq.sv
module swc_txn_seq
    import split_write_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 8,
    parameter int MAX_REGS = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [CNT_W-1:0]  txn_count,
    input  logic              wd_valid,
    input  logic [REG_W-1:0]  wd_data,
    output logic              beat_valid,
    output logic [ADDR_W-1:0] beat_addr,
    output logic [REG_W-1:0]  beat_data,
    output logic              count_err
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_REGS);

    typedef struct packed {
        logic              active;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  remain;
    } seq_t;

    seq_t s_d, s_q;
    logic count_bad;

    always_comb begin
        count_bad  = (txn_count == '0) || (txn_count > MAX_C);
        count_err  = txn_start && count_bad;
        beat_valid = !txn_start && wd_valid && s_q.active;
        beat_addr  = s_q.addr;
        beat_data  = wd_data;
        s_d        = s_q;
        if (txn_start) begin
            s_d.active = !count_bad;
            s_d.addr   = txn_addr;
            s_d.remain = txn_count;
        end else if (beat_valid) begin
            s_d.addr   = s_q.addr + 1'b1;
            s_d.remain = s_q.remain - 1'b1;
            s_d.active = (s_q.remain != CNT_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: a rejected request leaves no words to accept
    p_reject_closes_r7: assert property (@(posedge clk) disable iff (rst)
        (txn_start && count_bad) |=> !s_q.active);

    // R6: an open request never has a zero or oversized remaining count
    p_remain_range_r6: assert property (@(posedge clk) disable iff (rst)
        s_q.active |-> (s_q.remain != '0 && s_q.remain <= MAX_C));

endmodule

// File: rtl/swc_addr_class.sv
module swc_addr_class
    import split_write_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int BOOL_END = 16,
    parameter int BYTE_END = 32,
    parameter int WORD_END = 64,
    parameter int PAIR_END = 128
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_class_e        cls
);

    localparam logic [ADDR_W:0] BOOL_E = (ADDR_W+1)'(BOOL_END);
    localparam logic [ADDR_W:0] BYTE_E = (ADDR_W+1)'(BYTE_END);
    localparam logic [ADDR_W:0] WORD_E = (ADDR_W+1)'(WORD_END);
    localparam logic [ADDR_W:0] PAIR_E = (ADDR_W+1)'(PAIR_END);

    logic [ADDR_W:0] a_ext;
    logic            is_upper;

    generate
        if (WORD_END % 2 == 0) begin : g_even_base
            assign is_upper = (addr[0] == 1'b0);
        end else begin : g_odd_base
            assign is_upper = (addr[0] == 1'b1);
        end
    endgenerate

    always_comb begin
        a_ext = {1'b0, addr};
        if (a_ext < BOOL_E) begin
            cls = CLS_BOOL;
        end else if (a_ext < BYTE_E) begin
            cls = CLS_BYTE;
        end else if (a_ext < WORD_E) begin
            cls = CLS_WORD;
        end else if (a_ext < PAIR_E) begin
            cls = is_upper ? CLS_HI : CLS_LO;
        end else begin
            cls = CLS_BAD;
        end
    end

endmodule

// File: rtl/swc_pair_combiner.sv
module swc_pair_combiner
    import split_write_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              count_err,
    input  logic              beat_valid,
    input  logic [ADDR_W-1:0] beat_addr,
    input  logic [REG_W-1:0]  beat_data,
    input  reg_class_e        beat_cls,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_idx,
    output logic [ENT_W-1:0]  st_data,
    output logic              err_pulse,
    output err_code_e         err_code
);

    typedef struct packed {
        logic              held;
        logic [ADDR_W-1:0] hold_addr;
        logic [REG_W-1:0]  hold_val;
        logic              we;
        logic [ADDR_W-1:0] idx;
        logic [ENT_W-1:0]  data;
        logic              err;
        err_code_e         code;
    } comb_t;

    comb_t c_d, c_q;
    logic  pair_match;

    always_comb begin
        pair_match = c_q.held &&
                     (beat_addr == ADDR_W'(c_q.hold_addr + 1'b1));
        c_d        = c_q;
        c_d.we     = 1'b0;
        c_d.idx    = '0;
        c_d.data   = '0;
        c_d.err    = 1'b0;
        c_d.code   = ERR_NONE;
        if (count_err) begin
            c_d.held = 1'b0;
            c_d.err  = 1'b1;
            c_d.code = ERR_BADCOUNT;
        end else if (beat_valid) begin
            c_d.held = 1'b0;
            unique case (beat_cls)
                CLS_HI: begin
                    c_d.held      = 1'b1;
                    c_d.hold_addr = beat_addr;
                    c_d.hold_val  = beat_data;
                end
                CLS_LO: begin
                    if (pair_match) begin
                        c_d.we   = 1'b1;
                        c_d.idx  = c_q.hold_addr;
                        c_d.data = {c_q.hold_val, beat_data};
                    end else begin
                        c_d.err  = 1'b1;
                        c_d.code = ERR_ORPHAN;
                    end
                end
                CLS_BOOL: begin
                    c_d.we   = 1'b1;
                    c_d.idx  = beat_addr;
                    c_d.data = {{(ENT_W-1){1'b0}}, (beat_data != '0)};
                end
                CLS_BYTE: begin
                    c_d.we   = 1'b1;
                    c_d.idx  = beat_addr;
                    c_d.data = {{(ENT_W-8){1'b0}}, beat_data[7:0]};
                end
                CLS_WORD: begin
                    c_d.we   = 1'b1;
                    c_d.idx  = beat_addr;
                    c_d.data = {{(ENT_W-REG_W){1'b0}}, beat_data};
                end
                default: begin
                    c_d.err  = 1'b1;
                    c_d.code = ERR_BADADDR;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign st_we     = c_q.we;
    assign st_idx    = c_q.idx;
    assign st_data   = c_q.data;
    assign err_pulse = c_q.err;
    assign err_code  = c_q.code;

    // R2: an upper half is held without touching the store
    p_hold_no_store_r2: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_cls == CLS_HI) |=> (!st_we && !err_pulse && c_q.held));

    // R3: matching lower half commits its own bits at the held index
    p_pair_commit_r3: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_cls == CLS_LO && pair_match) |=>
        (st_we && st_data[15:0] == $past(beat_data) && st_idx == $past(c_q.hold_addr)));

    // R3: commit and error are exclusive
    p_excl_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        !(st_we && err_pulse));

    // R4: unmatched lower half is an orphan error
    p_orphan_err_r4: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_cls == CLS_LO && !pair_match) |=>
        (err_pulse && err_code == ERR_ORPHAN && !st_we && !c_q.held));

    // R7: illegal count is reported
    p_bad_count_r7: assert property (@(posedge clk) disable iff (rst)
        count_err |=> (err_pulse && err_code == ERR_BADCOUNT));

    // R8: boolean commits are 0 or 1
    p_bool_value_r8: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_cls == CLS_BOOL) |=>
        (st_we && st_data == {31'b0, ($past(beat_data) != 16'h0)}));

    // R11: unmapped address is reported
    p_bad_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (beat_valid && beat_cls == CLS_BAD) |=>
        (err_pulse && err_code == ERR_BADADDR));

endmodule

// File: rtl/split_write_combiner.sv
module split_write_combiner
    import split_write_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int CNT_W    = 8,
    parameter int MAX_REGS = 24,
    parameter int BOOL_END = 16,
    parameter int BYTE_END = 32,
    parameter int WORD_END = 64,
    parameter int PAIR_END = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              txn_start,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [CNT_W-1:0]  txn_count,
    input  logic              wd_valid,
    input  logic [15:0]       wd_data,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_idx,
    output logic [31:0]       st_data,
    output logic              err_pulse,
    output logic [1:0]        err_code
);

    logic              beat_valid;
    logic [ADDR_W-1:0] beat_addr;
    logic [REG_W-1:0]  beat_data;
    logic              count_err;
    reg_class_e        beat_cls;
    err_code_e         code_e;

    swc_txn_seq #(
        .ADDR_W   (ADDR_W),
        .CNT_W    (CNT_W),
        .MAX_REGS (MAX_REGS)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .txn_start  (txn_start),
        .txn_addr   (txn_addr),
        .txn_count  (txn_count),
        .wd_valid   (wd_valid),
        .wd_data    (wd_data),
        .beat_valid (beat_valid),
        .beat_addr  (beat_addr),
        .beat_data  (beat_data),
        .count_err  (count_err)
    );

    swc_addr_class #(
        .ADDR_W   (ADDR_W),
        .BOOL_END (BOOL_END),
        .BYTE_END (BYTE_END),
        .WORD_END (WORD_END),
        .PAIR_END (PAIR_END)
    ) i_class (
        .addr (beat_addr),
        .cls  (beat_cls)
    );

    swc_pair_combiner #(
        .ADDR_W (ADDR_W)
    ) i_comb (
        .clk        (clk),
        .rst        (rst),
        .count_err  (count_err),
        .beat_valid (beat_valid),
        .beat_addr  (beat_addr),
        .beat_data  (beat_data),
        .beat_cls   (beat_cls),
        .st_we      (st_we),
        .st_idx     (st_idx),
        .st_data    (st_data),
        .err_pulse  (err_pulse),
        .err_code   (code_e)
    );

    assign err_code = code_e;

    // R12: idle outputs read zero
    p_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
        (!st_we && !err_pulse) |-> (st_idx == '0 && st_data == '0 && err_code == 2'd0));

endmodule

// File: tb/test_split_write_combiner.sv
module test_split_write_combiner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        txn_start = 1'b0;
    logic [7:0]  txn_addr = '0;
    logic [7:0]  txn_count = '0;
    logic        wd_valid = 1'b0;
    logic [15:0] wd_data = '0;
    logic        st_we;
    logic [7:0]  st_idx;
    logic [31:0] st_data;
    logic        err_pulse;
    logic [1:0]  err_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    split_write_combiner i_split_write_combiner (
        .clk       (clk),
        .rst       (rst),
        .txn_start (txn_start),
        .txn_addr  (txn_addr),
        .txn_count (txn_count),
        .wd_valid  (wd_valid),
        .wd_data   (wd_data),
        .st_we     (st_we),
        .st_idx    (st_idx),
        .st_data   (st_data),
        .err_pulse (err_pulse),
        .err_code  (err_code)
    );

    task automatic check_out(string req, logic we, logic [7:0] idx,
                             logic [31:0] data, logic err, logic [1:0] code);
        checks++;
        if (st_we !== we || st_idx !== idx || st_data !== data ||
            err_pulse !== err || err_code !== code) begin
            failures++;
            $display("FAIL %s: actual we=%0b idx=%0d data=%h err=%0b code=%0d expected we=%0b idx=%0d data=%h err=%0b code=%0d",
                     req, st_we, st_idx, st_data, err_pulse, err_code,
                     we, idx, data, err, code);
        end
    endtask

    task automatic expect_idle(string req);
        check_out(req, 1'b0, 8'd0, 32'd0, 1'b0, 2'd0);
    endtask

    task automatic expect_commit(string req, logic [7:0] idx, logic [31:0] data);
        check_out(req, 1'b1, idx, data, 1'b0, 2'd0);
    endtask

    task automatic expect_err(string req, logic [1:0] code);
        check_out(req, 1'b0, 8'd0, 32'd0, 1'b1, code);
    endtask

    // inputs change at negedge; results sampled one negedge later
    task automatic start_txn(logic [7:0] addr, logic [7:0] cnt);
        txn_start = 1'b1;
        txn_addr  = addr;
        txn_count = cnt;
        @(negedge clk);
        txn_start = 1'b0;
    endtask

    task automatic send_word(logic [15:0] d);
        wd_valid = 1'b1;
        wd_data  = d;
        @(negedge clk);
        wd_valid = 1'b0;
    endtask

    task automatic single(logic [7:0] addr, logic [15:0] d);
        start_txn(addr, 8'd1);
        send_word(d);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        expect_idle("R12 reset state");
    endtask

    task automatic t_split_pair();
        single(8'd64, 16'h1234);
        expect_idle("R2 upper half held, no store write");
        single(8'd65, 16'hABCD);
        expect_commit("R1 R3 pair commit", 8'd64, 32'h1234ABCD);
        @(negedge clk);
        expect_idle("R3 strobe lasts one cycle");
    endtask

    task automatic t_orphan();
        single(8'd67, 16'h5555);
        expect_err("R4 orphan lower half", 2'd1);
        single(8'd67, 16'h5555);
        expect_err("R4 held state still empty", 2'd1);
    endtask

    task automatic t_discard();
        single(8'd66, 16'h7777);
        single(8'd3, 16'h0000);
        expect_commit("R8 boolean zero", 8'd3, 32'd0);
        single(8'd67, 16'h1111);
        expect_err("R5 held half discarded by other write", 2'd1);
        single(8'd66, 16'h2222);
        single(8'd68, 16'h3333);
        expect_idle("R2 second upper replaces first");
        single(8'd69, 16'h4444);
        expect_commit("R2 replaced upper pairs with its own lower", 8'd68, 32'h33334444);
    endtask

    task automatic t_multi();
        start_txn(8'd70, 8'd4);
        send_word(16'hA0A0);
        expect_idle("R6 multi word 0 held");
        send_word(16'hB1B1);
        expect_commit("R6 multi first pair", 8'd70, 32'hA0A0B1B1);
        send_word(16'hC2C2);
        expect_idle("R6 multi word 2 held");
        send_word(16'hD3D3);
        expect_commit("R6 multi second pair", 8'd72, 32'hC2C2D3D3);
        send_word(16'hEEEE);
        expect_idle("R6 word beyond count ignored");
    endtask

    task automatic t_small_types();
        start_txn(8'd15, 8'd2);
        send_word(16'h0100);
        expect_commit("R8 boolean non-zero reads 1", 8'd15, 32'd1);
        send_word(16'hFFA5);
        expect_commit("R9 byte keeps low byte only", 8'd16, 32'h000000A5);
        single(8'd40, 16'h8001);
        expect_commit("R10 16-bit zero-extended", 8'd40, 32'h00008001);
    endtask

    task automatic t_counts();
        start_txn(8'd64, 8'd25);
        expect_err("R7 count 25 rejected", 2'd3);
        send_word(16'h1234);
        expect_idle("R7 word after rejected request ignored");
        start_txn(8'd10, 8'd0);
        expect_err("R7 count 0 rejected", 2'd3);
        start_txn(8'd64, 8'd24);
        expect_idle("R7 count 24 accepted");
        for (int i = 0; i < 24; i++) begin
            send_word(16'h1000 + 16'(i));
            if (i % 2 == 0) begin
                expect_idle("R6 upper held in long request");
            end else begin
                expect_commit("R6 pair in long request", 8'(64 + i - 1),
                              {16'h1000 + 16'(i - 1), 16'h1000 + 16'(i)});
            end
        end
        wd_valid = 1'b1;
        txn_start = 1'b1;
        txn_addr = 8'd5;
        txn_count = 8'd1;
        wd_data = 16'h0001;
        @(negedge clk);
        txn_start = 1'b0;
        wd_valid = 1'b0;
        expect_idle("R6 word with start ignored");
    endtask

    task automatic t_bad_addr();
        single(8'd130, 16'h0001);
        expect_err("R11 unmapped address", 2'd2);
        single(8'd128, 16'h0001);
        expect_err("R11 first unmapped address", 2'd2);
        single(8'd127, 16'h0001);
        expect_err("R4 last pair lower orphan", 2'd1);
    endtask

    task automatic t_reset_drops_hold();
        single(8'd64, 16'h9999);
        do_reset();
        expect_idle("R12 idle after reset");
        single(8'd65, 16'h8888);
        expect_err("R12 reset clears held half", 2'd1);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_split_pair();
        t_orphan();
        t_discard();
        t_multi();
        t_small_types();
        t_counts();
        t_bad_addr();
        t_reset_drops_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual running expected finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule